// File: doc/BRIEF.md
# General-Purpose Event Register Block with SCI Level Control

This block holds a small general-purpose event (GPE) register window behind a byte-wide I/O bus. The lower half of the window is an array of status bytes and the upper half is an equal array of enable bytes, one byte per address. A single hardware source, a hotplug event pulse, sets a fixed status bit (bit 3 of status byte 0). When the matching enable bit is set, the pulse also raises a level-type system control interrupt (SCI) output. Software acknowledges the event by writing ones to status bits. Writing ones clears those bits. Software masks the event by rewriting the enable byte. Either action drops the SCI while it is raised.

A second, read-only window at a separate base presents a processor-present bitmap, one bit per processor slot and 32 bytes deep. Its reset contents mark the first `PRESENT_CPUS` slots as present. Writes to that window are discarded. Reads anywhere else, or with the read strobe low, return zero. Reads are combinational from the address. Writes and the hotplug pulse take effect at the rising clock edge.

Top module: `gpe_sci_block`

## Requirements
- R1: After synchronous reset every status byte and every enable byte reads 0x00 and `sci_level` is 0.
- R2: Status byte k sits at `GPE_BASE+k` and enable byte k at `GPE_BASE+GPE_LEN/2+k`. Any read outside the GPE and processor windows, or with `bus_rd` low, returns 0x00.
- R3: A status write clears each bit written as 1 and leaves bits written as 0 unchanged. No status bit other than bit 3 of status byte 0 ever becomes 1.
- R4: A one-cycle `hp_evt` pulse sets bit 3 of status byte 0. If bit 3 of enable byte 0 is 1 (including a value written in the same cycle), `sci_level` is 1 from the next cycle. `sci_level` rises only in the cycle after an `hp_evt` pulse.
- R5: While `sci_level` is 1, a status write that turns bit 3 of status byte 0 from 1 to 0 drops `sci_level` in the next cycle. A status write that leaves that bit set keeps `sci_level` at 1.
- R6: While `sci_level` is 1, a write to enable byte 0 with bit 3 = 0 drops `sci_level` in the next cycle. Writes to other enable bytes, or to enable byte 0 with bit 3 = 1, keep it at 1.
- R7: An enable write stores the written byte unchanged, and it reads back as written.
- R8: Setting enable bit 3 while status bit 3 is already pending does not raise `sci_level`.
- R9: When `hp_evt` and a status write clearing bit 3 fall in the same cycle, the event wins. Status bit 3 stays 1, and `sci_level` is 1 if enable bit 3 is set.
- R10: Processor byte j at `CPU_BASE+j` (j < `CPU_BYTES`) has bit b set exactly when 8*j+b < `PRESENT_CPUS`. With the default of 1, byte 0 reads 0x01 and the others 0x00. Writes to this window change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 16 | I/O byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| hp_evt | input | 1 | Hotplug event pulse |
| sci_level | output | 1 | SCI interrupt level |

## Verification
The bench builds the block with its default parameters: a four-byte GPE window at 0x0C08, which gives two status and two enable bytes, and a 32-byte processor window at 0xAF00 with one processor present. Two bytes per half let the bench show that writes to the second enable byte never drop the interrupt, while the first enable byte does. They also let it probe the address just past each window edge. A single present processor puts the boundary between set and clear bits inside byte 0, so reads of bytes 0, 1 and 31, and of the address one past the end, cover the whole shape of the bitmap.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

    typedef logic [7:0] byte_t;

    // Which register window an address falls into
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_STS  = 2'd1,
        RGN_EN   = 2'd2,
        RGN_CPU  = 2'd3
    } region_e;

    // Decoded bus access: window plus byte offset inside it
    typedef struct packed {
        region_e region;
        byte_t   off;
    } bus_sel_t;

    // Bit b of processor byte idx is set when slot 8*idx+b is populated
    function automatic byte_t present_byte(int unsigned count, byte_t idx);
        byte_t r;
        for (int unsigned b = 0; b < 8; b++) begin
            r[b] = ((int'(idx) * 8 + b) < count);
        end
        return r;
    endfunction

    // Single-bit mask inside one byte
    function automatic byte_t bit_mask(int unsigned pos);
        byte_t m;
        m = '0;
        m[pos[2:0]] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gpe_addr_dec.sv
module gpe_addr_dec
    import gpe_pkg::*;
#(
    parameter logic [15:0] GPE_BASE  = 16'h0C08,
    parameter int          GPE_LEN   = 4,
    parameter logic [15:0] CPU_BASE  = 16'hAF00,
    parameter int          CPU_BYTES = 32
) (
    input  logic [15:0] addr,
    output bus_sel_t    sel
);
    localparam int HALF = GPE_LEN / 2;

    logic [15:0] g_off;
    logic [15:0] c_off;

    // Wrapping subtraction: addresses below a base land far above the window
    assign g_off = addr - GPE_BASE;
    assign c_off = addr - CPU_BASE;

    always_comb begin
        sel.region = RGN_NONE;
        sel.off    = '0;
        if (g_off < 16'(HALF)) begin
            sel.region = RGN_STS;
            sel.off    = g_off[7:0];
        end else if (g_off < 16'(GPE_LEN)) begin
            sel.region = RGN_EN;
            sel.off    = 8'(g_off - 16'(HALF));
        end else if (c_off < 16'(CPU_BYTES)) begin
            sel.region = RGN_CPU;
            sel.off    = c_off[7:0];
        end
    end

endmodule

// File: rtl/gpe_event_regs.sv
module gpe_event_regs
    import gpe_pkg::*;
#(
    parameter int HALF   = 2,
    parameter int HP_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  bus_sel_t          sel,
    input  byte_t             wdata,
    input  logic              hp_evt,
    output logic [HALF*8-1:0] sts_q,
    output logic [HALF*8-1:0] en_q,
    output logic              sci_q
);
    localparam int    W       = HALF * 8;
    localparam int    HP_BYTE = HP_BIT / 8;
    localparam int    HP_FLAT = HP_BYTE * 8 + (HP_BIT % 8);
    localparam byte_t HP_MASK = bit_mask(HP_BIT % 8);

    logic [W-1:0]    sts_d;
    logic [W-1:0]    en_d;
    logic [HALF-1:0] wr_sts;
    logic [HALF-1:0] wr_en;
    logic            sci_d;

    // Per-byte next state: write-1-to-clear status, event OR-in, plain enable store
    for (genvar g = 0; g < HALF; g++) begin : g_byte
        assign wr_sts[g] = wr && (sel.region == RGN_STS) && (sel.off == 8'(g));
        assign wr_en[g]  = wr && (sel.region == RGN_EN)  && (sel.off == 8'(g));

        assign sts_d[g*8 +: 8] = (sts_q[g*8 +: 8] & ~(wr_sts[g] ? wdata : 8'h00))
                               | ((hp_evt && (g == HP_BYTE)) ? HP_MASK : 8'h00);
        assign en_d[g*8 +: 8]  = wr_en[g] ? wdata : en_q[g*8 +: 8];
    end

    // SCI flag: drop on acknowledge or mask, raise on an enabled event (raise wins)
    always_comb begin
        sci_d = sci_q;
        if (sci_q && sts_q[HP_FLAT] && !sts_d[HP_FLAT]) begin
            sci_d = 1'b0;
        end
        if (sci_q && wr_en[HP_BYTE] && !wdata[HP_BIT % 8]) begin
            sci_d = 1'b0;
        end
        if (hp_evt && en_d[HP_FLAT]) begin
            sci_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
            sci_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
            sci_q <= sci_d;
        end
    end

    // R1: state observed one cycle after reset is clear
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (sts_q == '0 && en_q == '0 && !sci_q));

    // R3: only the hotplug status bit can ever be set
    p_only_hp_status_r3: assert property (@(posedge clk) disable iff (rst)
        ((sts_q & ~(W'(1) << HP_FLAT)) == '0));

    // R4: the SCI rises only after an event pulse
    p_sci_rise_on_event_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sci_q) |-> $past(hp_evt));

    // R5: a raised SCI always has its status bit pending
    p_sci_has_status_r5: assert property (@(posedge clk) disable iff (rst)
        sci_q |-> sts_q[HP_FLAT]);

    // R6: a raised SCI always has its enable bit set
    p_sci_has_enable_r6: assert property (@(posedge clk) disable iff (rst)
        sci_q |-> en_q[HP_FLAT]);

    // R8: enabling a pending bit without an event never raises the SCI
    p_no_late_raise_r8: assert property (@(posedge clk) disable iff (rst)
        (!sci_q && !hp_evt) |=> !sci_q);

endmodule

// File: rtl/cpu_present_map.sv
module cpu_present_map
    import gpe_pkg::*;
#(
    parameter int CPU_BYTES    = 32,
    parameter int PRESENT_CPUS = 1
) (
    input  bus_sel_t sel,
    output byte_t    data
);
    // Read-only constant map: no storage, so bus writes cannot reach it
    always_comb begin
        data = '0;
        if (sel.region == RGN_CPU && int'(sel.off) < CPU_BYTES) begin
            data = present_byte(PRESENT_CPUS, sel.off);
        end
    end

endmodule

// File: rtl/gpe_sci_block.sv
module gpe_sci_block
    import gpe_pkg::*;
#(
    parameter logic [15:0] GPE_BASE     = 16'h0C08,
    parameter int          GPE_LEN      = 4,
    parameter logic [15:0] CPU_BASE     = 16'hAF00,
    parameter int          CPU_BYTES    = 32,
    parameter int          PRESENT_CPUS = 1,
    parameter int          HP_BIT       = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        hp_evt,
    output logic        sci_level
);
    localparam int HALF = GPE_LEN / 2;

    bus_sel_t          sel;
    logic [HALF*8-1:0] sts_flat;
    logic [HALF*8-1:0] en_flat;
    byte_t             cpu_byte;

    gpe_addr_dec #(
        .GPE_BASE (GPE_BASE),
        .GPE_LEN  (GPE_LEN),
        .CPU_BASE (CPU_BASE),
        .CPU_BYTES(CPU_BYTES)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    gpe_event_regs #(
        .HALF  (HALF),
        .HP_BIT(HP_BIT)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .hp_evt(hp_evt),
        .sts_q (sts_flat),
        .en_q  (en_flat),
        .sci_q (sci_level)
    );

    cpu_present_map #(
        .CPU_BYTES   (CPU_BYTES),
        .PRESENT_CPUS(PRESENT_CPUS)
    ) u_cpu (
        .sel (sel),
        .data(cpu_byte)
    );

    // Read mux; the decoder bounds the offset inside each window
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel.region)
                RGN_STS:  bus_rdata = sts_flat[int'(sel.off)*8 +: 8];
                RGN_EN:   bus_rdata = en_flat[int'(sel.off)*8 +: 8];
                RGN_CPU:  bus_rdata = cpu_byte;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2: a read with the strobe low never returns data
    p_idle_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00));

endmodule

// File: tb/gpe_sci_block_test.sv
module gpe_sci_block_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        hp_evt = 1'b0;
    logic        sci_level;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    gpe_sci_block uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hp_evt(hp_evt), .sci_level(sci_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: op[47:44] (1 write, 2 read, 3 event), req[43:36], addr[35:20],
    // data[19:12], expected read data[11:4], expected sci[3:0]
    localparam int NV = 32;
    localparam logic [47:0] VEC [0:NV-1] = '{
        48'h2_01_0C08_00_00_0, // R1 status 0 clear
        48'h2_01_0C0A_00_00_0, // R1 enable 0 clear
        48'h1_07_0C0A_08_00_0, // R7 enable bit 3
        48'h2_07_0C0A_00_08_0, // R7 read back
        48'h3_04_0000_00_00_1, // R4 event raises sci
        48'h2_04_0C08_00_08_1, // R4 status bit 3 set
        48'h1_05_0C08_00_00_1, // R5 write zeros keeps sci
        48'h1_05_0C08_04_00_1, // R5 clear other bit keeps sci
        48'h2_03_0C08_00_08_1, // R3 bit 3 unchanged
        48'h1_05_0C08_08_00_0, // R5 ack drops sci
        48'h2_03_0C08_00_00_0, // R3 bit cleared
        48'h3_04_0000_00_00_1, // R4 raise again
        48'h1_06_0C0A_00_00_0, // R6 mask drops sci
        48'h2_06_0C08_00_08_0, // R6 status still pending
        48'h1_08_0C0A_08_00_0, // R8 re-enable no raise
        48'h1_03_0C08_FF_00_0, // R3 clear all
        48'h2_03_0C08_00_00_0, // R3 read cleared
        48'h1_07_0C0B_A5_00_0, // R7 enable byte 1
        48'h2_07_0C0B_00_A5_0, // R7 read back byte 1
        48'h2_03_0C09_00_00_0, // R3 status byte 1 stays 0
        48'h2_0A_AF00_00_01_0, // R10 cpu byte 0
        48'h1_0A_AF00_FF_00_0, // R10 write ignored
        48'h2_0A_AF00_00_01_0, // R10 still 0x01
        48'h2_0A_AF1F_00_00_0, // R10 last byte
        48'h2_02_AF20_00_00_0, // R2 past cpu window
        48'h2_02_0C0C_00_00_0, // R2 past gpe window
        48'h2_02_0C07_00_00_0, // R2 below gpe window
        48'h3_04_0000_00_00_1, // R4 raise
        48'h1_06_0C0B_00_00_1, // R6 other enable byte keeps sci
        48'h1_06_0C0A_0C_00_1, // R6 bit 3 kept keeps sci
        48'h1_06_0C0A_F7_00_0, // R6 bit 3 off drops sci
        48'h2_07_0C0A_00_F7_0  // R7 read back F7
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Drive at a negedge, let one posedge pass, sample at the next negedge
    task automatic do_op(input logic [3:0] op, input logic [15:0] a,
                         input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = (op == 4'd1);
        bus_rd    = (op == 4'd2);
        hp_evt    = (op == 4'd3);
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_rd = 1'b0; hp_evt = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [15:0] a,
                            input logic [7:0] exp);
        do_op(4'd2, a, 8'h00);
        check(req, "read", bus_rdata, exp);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset outputs
        check("R1", "sci after reset", {7'd0, sci_level}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            string rq;
            v = VEC[i];
            rq = $sformatf("R%0d", v[43:36]);
            do_op(v[47:44], v[35:20], v[19:12]);
            if (v[47:44] == 4'd2) check(rq, "vector read", bus_rdata, v[11:4]);
            check(rq, "vector sci", {7'd0, sci_level}, {7'd0, v[0]});
            idle();
        end

        // R9: event and acknowledge in the same cycle; event wins
        do_op(4'd1, 16'h0C0A, 8'h08);
        idle();
        @(negedge clk);
        bus_addr = 16'h0C08; bus_wdata = 8'h08; bus_wr = 1'b1; hp_evt = 1'b1;
        @(negedge clk);
        idle();
        check("R9", "sci after collision", {7'd0, sci_level}, 8'h01);
        read_chk("R9", 16'h0C08, 8'h08);

        // R4: event with enable written in the same cycle raises sci
        do_op(4'd1, 16'h0C08, 8'h08);
        idle();
        do_op(4'd1, 16'h0C0A, 8'h00);
        idle();
        check("R6", "masked", {7'd0, sci_level}, 8'h00);
        @(negedge clk);
        bus_addr = 16'h0C0A; bus_wdata = 8'h08; bus_wr = 1'b1; hp_evt = 1'b1;
        @(negedge clk);
        idle();
        check("R4", "same-cycle enable raise", {7'd0, sci_level}, 8'h01);

        // R2: read strobe low returns zero even on a populated register
        @(negedge clk);
        bus_addr = 16'h0C0A; bus_rd = 1'b0;
        #1;
        check("R2", "strobe low", bus_rdata, 8'h00);

        // R10: whole processor map
        for (int j = 0; j < 32; j++) begin
            read_chk("R10", 16'hAF00 + 16'(j), (j == 0) ? 8'h01 : 8'h00);
        end

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "sci after mid reset", {7'd0, sci_level}, 8'h00);
        read_chk("R1", 16'h0C08, 8'h00);
        read_chk("R1", 16'h0C0A, 8'h00);
        read_chk("R1", 16'h0C0B, 8'h00);
        read_chk("R1", 16'hAF00, 8'h01);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule